// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a simple internal request/acknowledge port and an external asynchronous 16-bit static RAM of 512K words. Each accepted request becomes one complete memory cycle on registered control pins: active-low chip select, output enable, write enable and one enable per byte lane. The 19-bit address and the 16-bit data bus go out through separate output-data, output-drive and input-data signals, so the pad ring supplies the tri-state cell.

Cycle lengths are parameters in nanoseconds. They are rounded up to whole clock periods. Reads hold chip select and output enable low for the access time and then capture the enabled lanes. Writes are controlled by the write-enable pin. The address, chip select, lane enables and data are set up one cycle before write enable falls. Write data stays driven for one cycle after write enable rises. A write that follows a read first waits a turnaround gap, so the memory can release the bus before the controller drives it.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, the chip select, output enable, write enable and both lane enable outputs are high. The data drive enable is low, ready is high and acknowledge is low.
- R2: A read holds chip select and output enable low for RD_CYC = ceil(T_ACC_NS/CLK_NS) cycles, starting at the accepting edge. Acknowledge is high for exactly the one cycle that starts RD_CYC edges after acceptance.
- R3: Read data returns memory lanes whose request enable bit is set and zero for the other lanes. Bit 1 of the byte enable selects bits 15:8 (upper lane pin) and bit 0 selects bits 7:0 (lower lane pin).
- R4: A write sets the address, chip select and lane enables at its start edge with write enable still high. Write enable then goes low for exactly max(ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS)) cycles, beginning one edge later.
- R5: Write data is driven from the first cycle of chip select low through the one cycle after write enable rises, and only the enabled lanes change in memory. Acknowledge is high in that cycle after the rise, and the drive enable is low in the next cycle.
- R6: The data drive enable is never high while output enable is low.
- R7: A write accepted directly after a read keeps all strobes high and the bus undriven for TA_CYC = ceil(T_TA_NS/CLK_NS) cycles before its start edge. A write after a write does not wait.
- R8: Ready is high only while idle. It is low from the cycle after acceptance through the acknowledge cycle, and high again in the following cycle.
- R9: A request with byte enable 00 keeps both lane enable outputs high. Such a write leaves memory unchanged and such a read returns zero.
- R10: While chip select is low, the address and lane enable outputs stay constant and equal the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_be | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle, request accepted on valid |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_o | output | 16 | Data to pad |
| mem_dq_oe | output | 1 | Pad drive enable |
| mem_dq_i | input | 16 | Data from pad |

## Verification
The assertions assume the following about the inputs:
- reset is held low from time zero;
- request fields are sampled only on the accepting edge;
- the memory drives read data on the input pins within the access window.

The stimulus raises valid only in cycles where ready is high and drops it right after acceptance. A behavioural memory model answers only to a legal read pin combination, and it puts a fixed filler pattern on disabled lanes so that the masking is visible. The sequences mix word, single-lane and empty-mask operations, back-to-back writes and write-after-read pairs, so both paths into the write start are covered.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW       = 19,
  parameter int DW       = 16,
  parameter int CLK_NS   = 20,
  parameter int T_ACC_NS = 55,
  parameter int T_WP_NS  = 45,
  parameter int T_DS_NS  = 30,
  parameter int T_TA_NS  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_ack,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  function automatic int cdiv(int a, int b);
    int q;
    q = (a + b - 1) / b;
    return (q < 1) ? 1 : q;
  endfunction

  localparam int LANE   = DW / 2;
  localparam int RD_CYC = cdiv(T_ACC_NS, CLK_NS);
  localparam int WP_CYC = cdiv(T_WP_NS, CLK_NS);
  localparam int DS_CYC = cdiv(T_DS_NS, CLK_NS);
  localparam int PULSE  = (WP_CYC > DS_CYC) ? WP_CYC : DS_CYC;
  localparam int TA_CYC = cdiv(T_TA_NS, CLK_NS);

  typedef enum logic [2:0] {
    IDLE, READ_ACCESS, READ_DONE, WRITE_SETUP, WRITE_PULSE, WRITE_END, TURNAROUND
  } state_t;

  state_t      state;
  logic [15:0] cnt;
  logic [1:0]  be_q;
  logic        rd_flag;
  logic        start_wr;
  logic [1:0]  wr_be;

  assign req_ready = (state == IDLE);
  assign start_wr  = (state == IDLE && req_valid && req_we && !rd_flag) ||
                     (state == TURNAROUND && cnt == 16'd0);
  assign wr_be     = (state == IDLE) ? req_be : be_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      be_q      <= '0;
      rd_flag   <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      rsp_ack <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          be_q     <= req_be;
          mem_dq_o <= req_wdata;
          if (!req_we) begin
            mem_cs_n <= 1'b0;
            mem_oe_n <= 1'b0;
            mem_ub_n <= ~req_be[1];
            mem_lb_n <= ~req_be[0];
            cnt      <= 16'(RD_CYC - 1);
            state    <= READ_ACCESS;
          end else if (rd_flag) begin
            cnt   <= 16'(TA_CYC - 1);
            state <= TURNAROUND;
          end
        end
        TURNAROUND: if (cnt != 16'd0) cnt <= cnt - 16'd1;
        READ_ACCESS: if (cnt == 16'd0) begin
          rsp_rdata <= mem_dq_i & {{LANE{be_q[1]}}, {LANE{be_q[0]}}};
          mem_cs_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          rsp_ack   <= 1'b1;
          rd_flag   <= 1'b1;
          state     <= READ_DONE;
        end else begin
          cnt <= cnt - 16'd1;
        end
        READ_DONE: state <= IDLE;
        WRITE_SETUP: begin
          mem_we_n <= 1'b0;
          cnt      <= 16'(PULSE - 1);
          state    <= WRITE_PULSE;
        end
        WRITE_PULSE: if (cnt == 16'd0) begin
          mem_we_n <= 1'b1;
          mem_cs_n <= 1'b1;
          mem_ub_n <= 1'b1;
          mem_lb_n <= 1'b1;
          rsp_ack  <= 1'b1;
          state    <= WRITE_END;
        end else begin
          cnt <= cnt - 16'd1;
        end
        WRITE_END: begin
          mem_dq_oe <= 1'b0;
          state     <= IDLE;
        end
        default: state <= IDLE;
      endcase
      if (start_wr) begin
        mem_cs_n  <= 1'b0;
        mem_ub_n  <= ~wr_be[1];
        mem_lb_n  <= ~wr_be[0];
        mem_dq_oe <= 1'b1;
        rd_flag   <= 1'b0;
        state     <= WRITE_SETUP;
      end
    end
  end

  logic [15:0] we_lo_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)         we_lo_cnt <= '0;
    else if (!mem_we_n) we_lo_cnt <= we_lo_cnt + 16'd1;
    else                we_lo_cnt <= '0;
  end

  // R6
  dq_drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  // R4
  we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 16'(PULSE)));
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);
  // R5
  data_before_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (mem_dq_oe && !mem_cs_n));
  // R10
  pins_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));
  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);
  // R8
  busy_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> !req_ready);
endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int RD = (55 + 19) / 20;
  localparam int WP = (45 + 19) / 20;
  localparam int DS = (30 + 19) / 20;
  localparam int P  = (WP > DS) ? WP : DS;
  localparam int TA = (20 + 19) / 20;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [18:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_ack, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [18:0] mem_addr;

  always #10 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  logic [15:0] pmem [256];
  logic [15:0] refm [256];
  int checks = 0, fails = 0, cyc = 0, exp_ack = -1, welo = 0, oelo = 0;
  logic [18:0] exp_addr = '0;
  logic [1:0]  exp_be = '0;
  bit after_read = 0, done = 0;

  assign mem_dq_i = (!mem_cs_n && !mem_oe_n && mem_we_n && !(mem_ub_n && mem_lb_n)) ?
    {mem_ub_n ? 8'hA5 : pmem[mem_addr[7:0]][15:8], mem_lb_n ? 8'h5A : pmem[mem_addr[7:0]][7:0]} : 16'hC33C;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && !done) begin
    chk(rsp_ack == (cyc == exp_ack), "R2/R8 ack timing", 32'(rsp_ack), 32'(cyc == exp_ack));
    if (mem_dq_oe) chk(mem_oe_n, "R6 drive with oe low", 32'(mem_oe_n), 1);
    if (!mem_cs_n) begin
      chk(mem_addr == exp_addr, "R10 address", 32'(mem_addr), 32'(exp_addr));
      chk({mem_ub_n, mem_lb_n} == ~exp_be, "R10/R9 lane pins", 32'({mem_ub_n, mem_lb_n}), 32'(~exp_be));
    end
    if (!mem_cs_n && !mem_we_n) begin
      chk(mem_dq_oe, "R5 data driven during write", 32'(mem_dq_oe), 1);
      if (!mem_ub_n) pmem[mem_addr[7:0]][15:8] = mem_dq_o[15:8];
      if (!mem_lb_n) pmem[mem_addr[7:0]][7:0]  = mem_dq_o[7:0];
    end
    if (!mem_we_n) welo++;
    else if (welo != 0) begin
      chk(welo == P, "R4 write pulse length", welo, P);
      welo = 0;
    end
    if (!mem_oe_n) oelo++;
    else if (oelo != 0) begin
      chk(oelo == RD, "R2 read strobe length", oelo, RD);
      oelo = 0;
    end
  end

  task automatic do_op(input bit we, input logic [18:0] a, input logic [1:0] be,
                       input logic [15:0] wd, input string tag);
    int n, lat;
    logic [15:0] m;
    m = {{8{be[1]}}, {8{be[0]}}};
    chk(req_ready, "R8 ready before request", 32'(req_ready), 1);
    n = cyc;
    lat = we ? (1 + P + (after_read ? TA : 0)) : RD;
    exp_addr = a; exp_be = be; exp_ack = n + 1 + lat;
    req_valid = 1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R8 busy after accept", 32'(req_ready), 0);
    if (we) begin
      for (int k = 0; k < (after_read ? TA : 0); k++) begin
        chk(mem_cs_n && !mem_dq_oe, "R7 turnaround idle", 32'({mem_cs_n, mem_dq_oe}), 32'b10);
        @(negedge clk);
      end
      chk(!mem_cs_n && mem_we_n && mem_dq_oe, "R4 setup before strobe",
          32'({mem_cs_n, mem_we_n, mem_dq_oe}), 32'b011);
    end else begin
      chk(!mem_cs_n && !mem_oe_n, "R2 read strobes", 32'({mem_cs_n, mem_oe_n}), 0);
    end
    while (cyc != exp_ack) @(negedge clk);
    if (we) begin
      chk(mem_we_n && mem_cs_n && mem_dq_oe, "R5 data held after strobe",
          32'({mem_we_n, mem_cs_n, mem_dq_oe}), 32'b111);
      refm[a[7:0]] = (refm[a[7:0]] & ~m) | (wd & m);
    end else begin
      chk(rsp_rdata == (refm[a[7:0]] & m), tag, 32'(rsp_rdata), 32'(refm[a[7:0]] & m));
    end
    after_read = !we;
    @(negedge clk);
    chk(req_ready, "R8 ready after ack", 32'(req_ready), 1);
    chk(!mem_dq_oe, "R5 bus released", 32'(mem_dq_oe), 0);
  endtask

  initial begin
    logic [31:0] s;
    for (int i = 0; i < 256; i++) begin
      pmem[i] = 16'(i * 257) ^ 16'h3C3C;
      refm[i] = pmem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R1 strobes high",
        32'({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1F);
    chk(!mem_dq_oe && req_ready && !rsp_ack, "R1 idle outputs",
        32'({mem_dq_oe, req_ready, rsp_ack}), 32'b010);
    do_op(0, 19'h7FF12, 2'b11, 0, "R3 word read");
    do_op(0, 19'h00013, 2'b10, 0, "R3 upper read");
    do_op(0, 19'h40014, 2'b01, 0, "R3 lower read");
    do_op(1, 19'h12320, 2'b11, 16'hBEEF, "");
    do_op(1, 19'h12321, 2'b10, 16'h1234, "");
    do_op(1, 19'h12322, 2'b01, 16'h5678, "");
    do_op(0, 19'h12320, 2'b11, 0, "R5 readback word");
    do_op(0, 19'h12321, 2'b11, 0, "R5 readback upper write");
    do_op(0, 19'h12322, 2'b11, 0, "R5 readback lower write");
    do_op(1, 19'h00030, 2'b00, 16'hFFFF, "");
    do_op(0, 19'h00030, 2'b11, 0, "R9 empty write left memory");
    do_op(0, 19'h00031, 2'b00, 0, "R9 empty read returns zero");
    do_op(1, 19'h00040, 2'b11, 16'hA1A1, "");
    do_op(0, 19'h00040, 2'b11, 0, "R7 read after turnaround write");
    s = 32'h1234_5678;
    for (int i = 0; i < 80; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      do_op(s[31], {s[26:16], s[7:0]}, s[29:28], s[23:8], "R3 mixed read");
    end
    for (int i = 0; i < 256; i++)
      chk(pmem[i] == refm[i], "R5 final memory image", 32'(pmem[i]), 32'(refm[i]));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule